// File: doc/BRIEF.md
# UART Modem Control and Loopback

This block holds the modem-control and modem-status logic of one UART channel. A byte-wide control register, written over a simple register port, drives three active-low modem outputs: data terminal ready, request to send and a general-purpose user output. Four active-low modem inputs (clear to send, data set ready, ring indicator and carrier detect) are brought into the clock domain through synchronizer chains. Their present state can be read back, and any change is latched into delta bits that can raise a modem-status interrupt.

The block also sits on the serial path between the channel's serializer, its deserializer and the pins. When the control register selects local loopback, the transmit stream from the serializer is fed straight to the deserializer input and the external receive pin is ignored. The transmit pin is held at the idle high level so that nothing reaches the line. The modem pins never affect the serial path.

A register read with `rdEn` high consumes the status register and clears its delta bits. With `rdEn` low, the addressed register can be looked at without side effects.

Top module: `uart_modem_ctl`

## Requirements
- R1: Bit 0 of the control register (address 0) drives `dtrN` inverted. Writing 1 makes it low and writing 0 makes it high, from the cycle after the write.
- R2: Bit 1 of the control register drives `rtsN` inverted, from the cycle after the write.
- R3: Bit 3 of the control register drives `out2N` inverted, from the cycle after the write.
- R4: While `rstN` is low, `dtrN`, `rtsN` and `out2N` are high and `msIrq` is low. After reset the control register reads 0 and no delta bit is set.
- R5: Status register (address 1) bits 4, 5, 6 and 7 show the active-high state of clear to send, data set ready, ring indicator and carrier detect. A pin change appears there two clock edges after it is applied.
- R6: A change in either direction on `ctsN`, `dsrN` or `dcdN` sets status bit 0, 1 or 3 respectively, three clock edges after the change. The bit stays set until it is cleared.
- R7: Status bit 2 is set only when `riN` goes from low to high. A high-to-low transition leaves it clear.
- R8: A read of the status register with `rdEn` high clears all four delta bits at the next edge. A change detected in that same cycle keeps its bit set. With `rdEn` low, reading has no side effect.
- R9: `msIrq` is high exactly when at least one delta bit is set and bit 0 of the interrupt-enable register (address 2) is 1.
- R10: While control bit 4 (loopback) is 1, `rxToDeser` follows `txSerial` and `rxPin` is ignored. While it is 0, `rxToDeser` follows `rxPin`.
- R11: While loopback is on, `txPin` is held high. Otherwise it follows `txSerial`.
- R12: The control register reads back the whole written byte, and address 3 reads 0. The modem inputs have no effect on `txPin` or `rxToDeser`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Read-consume strobe (clears deltas on a status read) |
| addr | input | 2 | Register select: 0 control, 1 status, 2 interrupt enable |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register |
| ctsN | input | 1 | Clear to send, active low |
| dsrN | input | 1 | Data set ready, active low |
| riN | input | 1 | Ring indicator, active low |
| dcdN | input | 1 | Carrier detect, active low |
| dtrN | output | 1 | Data terminal ready, active low |
| rtsN | output | 1 | Request to send, active low |
| out2N | output | 1 | User output, active low |
| msIrq | output | 1 | Modem-status interrupt |
| txSerial | input | 1 | Transmit stream from the serializer |
| rxPin | input | 1 | External receive pin |
| txPin | output | 1 | External transmit pin |
| rxToDeser | output | 1 | Receive stream to the deserializer |

## Verification
On every cycle, the assertions compare the three modem outputs, the interrupt gating and the loopback routing with a shadow of the register writes seen at the port. The synchronizer latency, the edge direction that sets the ring flag, the clear-on-read priority against a change in the same cycle, and the isolation of the serial path from the modem pins depend on specific pin sequences. Only the bench's directed scenarios can show those.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int MDM_DATA_W    = 8;
  localparam int MDM_ADDR_W    = 2;
  localparam int MDM_NUM_IN    = 4;
  localparam int MDM_SYNC_LEN  = 2;

  // register select values
  localparam logic [MDM_ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [MDM_ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [MDM_ADDR_W-1:0] ADDR_IEN  = 2'd2;

  // control register bit positions
  localparam int BIT_DTR  = 0;
  localparam int BIT_RTS  = 1;
  localparam int BIT_OUT2 = 3;
  localparam int BIT_LOOP = 4;

  // modem input index: 0 cts, 1 dsr, 2 ring, 3 carrier
  localparam int RING_IDX = 2;

  typedef struct packed {
    logic clrDelta;
    logic loopEn;
  } mdmStrobe_t;
endpackage

// File: rtl/modem_ctl_regs.sv
module modem_ctl_regs
  import uart_modem_pkg::*;
#(
  parameter int DATA_W = MDM_DATA_W,
  parameter int ADDR_W = MDM_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] statusWord,
  input  logic              anyDelta,
  output logic [DATA_W-1:0] rdData,
  output logic              dtrN,
  output logic              rtsN,
  output logic              out2N,
  output logic              msIrq,
  output mdmStrobe_t        strobe
);
  logic [DATA_W-1:0] ctrlQ;
  logic              ienQ;
  logic              selCtrl, selStat, selIen;

  assign selCtrl = (addr == ADDR_CTRL);
  assign selStat = (addr == ADDR_STAT);
  assign selIen  = (addr == ADDR_IEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      ienQ  <= 1'b0;
    end else if (wrEn) begin
      if (selCtrl) ctrlQ <= wrData;
      if (selIen)  ienQ  <= wrData[0];
    end
  end

  // active-low pins: inverted control bits
  assign dtrN  = ~ctrlQ[BIT_DTR];
  assign rtsN  = ~ctrlQ[BIT_RTS];
  assign out2N = ~ctrlQ[BIT_OUT2];
  assign msIrq = ienQ & anyDelta;

  assign strobe.clrDelta = rdEn & selStat;
  assign strobe.loopEn   = ctrlQ[BIT_LOOP];

  always_comb begin
    rdData = '0;
    if (selCtrl)      rdData = ctrlQ;
    else if (selStat) rdData = statusWord;
    else if (selIen)  rdData[0] = ienQ;
  end
endmodule

// File: rtl/modem_status_path.sv
module modem_status_path
  import uart_modem_pkg::*;
#(
  parameter int NUM_IN   = MDM_NUM_IN,
  parameter int SYNC_LEN = MDM_SYNC_LEN,
  parameter int RING_AT  = RING_IDX
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_IN-1:0]   pinN,
  input  mdmStrobe_t          strobe,
  input  logic                txSerial,
  input  logic                rxPin,
  output logic [2*NUM_IN-1:0] statusWord,
  output logic                anyDelta,
  output logic                txPin,
  output logic                rxToDeser
);
  logic [NUM_IN-1:0] levelN;
  logic [NUM_IN-1:0] prevN;
  logic [NUM_IN-1:0] deltaQ;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic [SYNC_LEN-1:0] chainQ;
    logic                hit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chainQ   <= '1;
        prevN[i] <= 1'b1;
      end else begin
        chainQ   <= {chainQ[SYNC_LEN-2:0], pinN[i]};
        prevN[i] <= chainQ[SYNC_LEN-1];
      end
    end
    assign levelN[i] = chainQ[SYNC_LEN-1];

    if (i == RING_AT) begin : g_rise
      assign hit = levelN[i] & ~prevN[i];
    end else begin : g_any
      assign hit = levelN[i] ^ prevN[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               deltaQ[i] <= 1'b0;
      else if (hit)            deltaQ[i] <= 1'b1;
      else if (strobe.clrDelta) deltaQ[i] <= 1'b0;
    end
  end

  assign statusWord = {~levelN, deltaQ};
  assign anyDelta   = |deltaQ;

  assign txPin     = strobe.loopEn ? 1'b1 : txSerial;
  assign rxToDeser = strobe.loopEn ? txSerial : rxPin;
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_modem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       dcdN,
  output logic       dtrN,
  output logic       rtsN,
  output logic       out2N,
  output logic       msIrq,
  input  logic       txSerial,
  input  logic       rxPin,
  output logic       txPin,
  output logic       rxToDeser
);
  mdmStrobe_t strobe;
  logic [7:0] statusWord;
  logic       anyDelta;

  modem_ctl_regs #(.DATA_W(8), .ADDR_W(2)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .statusWord(statusWord), .anyDelta(anyDelta),
    .rdData(rdData), .dtrN(dtrN), .rtsN(rtsN), .out2N(out2N),
    .msIrq(msIrq), .strobe(strobe)
  );

  modem_status_path #(.NUM_IN(4), .SYNC_LEN(MDM_SYNC_LEN), .RING_AT(RING_IDX)) u_dp (
    .clk(clk), .rstN(rstN), .pinN({dcdN, riN, dsrN, ctsN}), .strobe(strobe),
    .txSerial(txSerial), .rxPin(rxPin), .statusWord(statusWord),
    .anyDelta(anyDelta), .txPin(txPin), .rxToDeser(rxToDeser)
  );
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic       dtrN,
  input logic       rtsN,
  input logic       out2N,
  input logic       msIrq,
  input logic       txSerial,
  input logic       txPin,
  input logic       rxToDeser
);
  logic [7:0] shadowCtrl;
  logic       shadowIen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCtrl <= '0;
      shadowIen  <= 1'b0;
    end else if (wrEn) begin
      if (addr == 2'd0) shadowCtrl <= wrData;
      if (addr == 2'd2) shadowIen  <= wrData[0];
    end
  end

  // R1
  dtr_level_chk: assert property (@(posedge clk) disable iff (!rstN) dtrN == !shadowCtrl[0]);
  // R2
  rts_level_chk: assert property (@(posedge clk) disable iff (!rstN) rtsN == !shadowCtrl[1]);
  // R3
  out2_level_chk: assert property (@(posedge clk) disable iff (!rstN) out2N == !shadowCtrl[3]);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN) msIrq |-> shadowIen);
  // R10
  loop_route_chk: assert property (@(posedge clk) disable iff (!rstN) shadowCtrl[4] |-> rxToDeser == txSerial);
  // R11
  loop_tx_idle_chk: assert property (@(posedge clk) disable iff (!rstN) shadowCtrl[4] |-> txPin);
  // R11
  tx_follow_chk: assert property (@(posedge clk) disable iff (!rstN) !shadowCtrl[4] |-> txPin == txSerial);
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .dtrN(dtrN), .rtsN(rtsN), .out2N(out2N), .msIrq(msIrq),
  .txSerial(txSerial), .txPin(txPin), .rxToDeser(rxToDeser)
);

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic dtrN, rtsN, out2N, msIrq;
  logic txSerial = 1'b0, rxPin = 1'b1;
  logic txPin, rxToDeser;

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_modem_ctl u_uart_modem_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ctsN(ctsN), .dsrN(dsrN), .riN(riN),
    .dcdN(dcdN), .dtrN(dtrN), .rtsN(rtsN), .out2N(out2N), .msIrq(msIrq),
    .txSerial(txSerial), .rxPin(rxPin), .txPin(txPin), .rxToDeser(rxToDeser)
  );

  // {write byte, expected {txPin(txSerial=0), out2N, rtsN, dtrN}}
  localparam logic [11:0] VEC [6] = '{
    {8'h01, 4'b0110}, {8'h02, 4'b0101}, {8'h08, 4'b0011},
    {8'h0B, 4'b0000}, {8'h10, 4'b1111}, {8'hE4, 4'b0111}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic peekStat(string req, logic [7:0] exp);
    addr = 2'd1;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic consume();
    addr = 2'd1; rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R4: outputs inactive during reset
    tick(2);
    check("R4 pins in reset", {5'd0, out2N, rtsN, dtrN}, 8'h07);
    check("R4 irq in reset", {7'd0, msIrq}, 8'h00);
    rstN = 1'b1;
    tick();
    addr = 2'd0; #1;
    check("R4 ctrl after reset", rdData, 8'h00);
    peekStat("R4 status after reset", 8'h00);

    // table walk: R1 R2 R3 R11 R12
    for (int v = 0; v < 6; v++) begin
      wr(2'd0, VEC[v][11:4]);
      txSerial = 1'b0; #1;
      check("R1/R2/R3/R11 pin vector", {4'd0, txPin, out2N, rtsN, dtrN}, {4'd0, VEC[v][3:0]});
      addr = 2'd0; #1;
      check("R12 ctrl readback", rdData, VEC[v][11:4]);
    end
    wr(2'd0, 8'h00);
    addr = 2'd3; #1;
    check("R12 unused address", rdData, 8'h00);

    // R5 R6: cts change
    ctsN = 1'b0;
    tick(2);
    peekStat("R5 state after two edges", 8'h10);
    tick();
    peekStat("R6 cts delta", 8'h11);
    peekStat("R8 peek no side effect", 8'h11);
    consume();
    peekStat("R8 read clears deltas", 8'h10);

    // R9: interrupt gating
    dsrN = 1'b0;
    tick(3);
    peekStat("R6 dsr delta", 8'h32);
    check("R9 irq disabled", {7'd0, msIrq}, 8'h00);
    wr(2'd2, 8'h01);
    check("R9 irq enabled", {7'd0, msIrq}, 8'h01);
    consume();
    check("R9 irq after clear", {7'd0, msIrq}, 8'h00);

    // R7: ring edges
    riN = 1'b0;
    tick(3);
    peekStat("R7 ring falling no flag", 8'h70);
    check("R7 no irq on falling ring", {7'd0, msIrq}, 8'h00);
    riN = 1'b1;
    tick(3);
    peekStat("R7 ring rising flag", 8'h34);
    consume();

    // R6: carrier
    dcdN = 1'b0;
    tick(3);
    peekStat("R6 dcd delta", 8'hB8);
    consume();
    peekStat("R8 cleared dcd", 8'hB0);

    // R8: change in same cycle as clear keeps its bit
    ctsN = 1'b1;
    tick(2);
    consume();
    peekStat("R8 set wins over clear", 8'hA1);
    consume();
    peekStat("R8 cleared after", 8'hA0);
    wr(2'd2, 8'h00);

    // R10 R11: loopback
    wr(2'd0, 8'h10);
    txSerial = 1'b0; rxPin = 1'b1; #1;
    check("R10 loop rx follows tx low", {7'd0, rxToDeser}, 8'h00);
    check("R11 loop tx idle", {7'd0, txPin}, 8'h01);
    txSerial = 1'b1; rxPin = 1'b0; #1;
    check("R10 loop rx follows tx high", {7'd0, rxToDeser}, 8'h01);
    wr(2'd0, 8'h00);
    txSerial = 1'b0; rxPin = 1'b1; #1;
    check("R10 normal rx path", {7'd0, rxToDeser}, 8'h01);
    check("R11 normal tx path", {7'd0, txPin}, 8'h00);

    // R12: modem pins do not touch the serial path
    ctsN = 1'b0; dsrN = 1'b1; riN = 1'b0; dcdN = 1'b1;
    tick(3);
    check("R12 pins no effect on tx", {7'd0, txPin}, 8'h00);
    check("R12 pins no effect on rx", {7'd0, rxToDeser}, 8'h01);

    // R4: reset mid-run
    wr(2'd0, 8'h1B);
    rstN = 1'b0; #1;
    check("R4 async reset pins", {5'd0, out2N, rtsN, dtrN}, 8'h07);
    tick();
    rstN = 1'b1;
    tick();
    addr = 2'd0; #1;
    check("R4 ctrl cleared", rdData, 8'h00);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule